// File: doc/BRIEF.md
# Misaligned Access Bus Splitter

This block sits between a CPU load/store port and a data bus that is narrower than the CPU word. It takes one request at a time (a byte, halfword or word at any address, read or write) and turns it into an ordered run of bus cycles. Each cycle's size is chosen from the current address alignment and the width of the path in use. On reads it places each returned chunk at its byte position in a 32-bit result, then pulses a done strobe carrying the assembled value. Writes get the same done strobe once their last cycle is acknowledged.

Two data paths are served. The peripheral path is always 16 bits wide. The external path is 16 bits wide, or 8 bits wide when `cfg_ext_narrow` is high. The request side is a valid/ready port. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold its fields stable while `req_valid` is high and `req_ready` is low. The bus side is valid/acknowledge. The block keeps a cycle on the bus until it sees `bus_ack`, so the bus applies back-pressure by holding the acknowledge low.

Top module: `access_splitter`

## Requirements
- R1: `req_size` codes are 0 = byte, 1 = halfword, 2 = word (3 is treated as a word). Any address is accepted for any size. A byte access takes exactly one bus cycle.
- R2: Data is little-endian. On the 16-bit path, the even-address byte uses lane 0 (`bus_wdata`/`bus_rdata` bits 7:0, `bus_be` bit 0) and the odd-address byte uses lane 1 (bits 15:8, `bus_be` bit 1). Cycles run from the lowest address upward, and the low part of the data goes first.
- R3: On the 16-bit path, a halfword at an odd address becomes two byte cycles, at the address and then at the address plus 1.
- R4: On the 16-bit path, a word at an odd address becomes three cycles in this order: byte at A, halfword at A+1, byte at A+3.
- R5: On the 16-bit path, a word whose address ends in binary 10 or 00 becomes two halfword cycles, at A and A+2 (`bus_be` = 11). An even-address halfword becomes one halfword cycle.
- R6: With the 8-bit external path selected, a halfword takes two byte cycles and a word takes four, at ascending addresses, for any alignment. Every cycle uses lane 0 only (`bus_be` = 01).
- R7: With `req_periph` high, the 16-bit splitting rules apply whatever the value of `cfg_ext_narrow`.
- R8: While `bus_valid` is high and `bus_ack` is low, the address, strobes, direction and write data hold steady. The next cycle is presented in the cycle after an acknowledge. Each cycle is acknowledged exactly once.
- R9: `rsp_valid` is a one-cycle pulse, high in the cycle after the last acknowledge. On reads, `rsp_rdata` holds the bytes read in little-endian order, zero-extended above the access size.
- R10: `req_ready` is high only while idle. It drops the cycle after a request is taken and returns the cycle after the `rsp_valid` pulse.
- R11: During and right after reset, `req_ready` is 1 and `bus_valid` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | AW | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, right-aligned |
| req_periph | input | 1 | Select the fixed 16-bit peripheral path |
| cfg_ext_narrow | input | 1 | External path width: 1 = 8 bits, 0 = 16 bits |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_rdata | output | 32 | Assembled read data |
| bus_valid | output | 1 | Bus cycle in progress |
| bus_addr | output | AW | Address of the current bus cycle |
| bus_be | output | 2 | Byte-lane strobes |
| bus_write | output | 1 | Direction of the current bus cycle |
| bus_wdata | output | 16 | Lane-placed write data |
| bus_ack | input | 1 | Bus completes the current cycle |
| bus_rdata | input | 16 | Read data, valid with `bus_ack` |

## Verification
The first bus cycle appears one cycle after the request edge. Each later cycle appears one cycle after the acknowledge of the one before it. The done pulse is high exactly one cycle after the final acknowledge, and `req_ready` returns one cycle after that. The bench's bus model samples and drives on falling edges and acknowledges after a random 0 to 2 cycle delay. Each transaction is checked by polling for the done pulse on falling edges, then checking that the pulse is gone and ready is back on the next falling edge. While waiting, the bench checks that ready stays low and that a held bus cycle does not change.

// File: rtl/access_splitter_pkg.sv
package access_splitter_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } split_state_e;

  localparam int CPU_BYTES = 4;
  localparam int OFF_W     = 3;
  localparam int LANES     = 2;

  // step descriptor: byte offset within the access and chunk width in bytes
  typedef struct packed {
    logic [OFF_W-1:0] off;
    logic [1:0]       nbytes;
    logic             last;
  } step_t;

  function automatic logic [OFF_W-1:0] size_to_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return OFF_W'(1);
      SZ_HALF: return OFF_W'(2);
      default: return OFF_W'(CPU_BYTES);
    endcase
  endfunction

endpackage

// File: rtl/split_step.sv
module split_step
  import access_splitter_pkg::*;
(
  input  logic             base_lsb,
  input  logic [OFF_W-1:0] off,
  input  logic [OFF_W-1:0] total,
  input  logic             narrow,
  output step_t            step
);
  logic [OFF_W-1:0] remain;
  logic             cur_odd;
  logic             one_byte;

  always_comb begin
    remain   = total - off;
    cur_odd  = base_lsb ^ off[0];
    // a byte cycle is forced by the narrow path, an odd address, or a lone tail byte
    one_byte = narrow || cur_odd || (remain == OFF_W'(1));
    step.off    = off;
    step.nbytes = one_byte ? 2'd1 : 2'd2;
    step.last   = (off + OFF_W'(step.nbytes)) == total;
  end
endmodule

// File: rtl/lane_steer.sv
module lane_steer
  import access_splitter_pkg::*;
(
  input  step_t         step,
  input  logic          cur_odd,
  input  logic          narrow,
  input  logic [31:0]   wdata,
  input  logic [31:0]   acc_in,
  input  logic [15:0]   bus_rdata,
  output logic [1:0]    be,
  output logic [15:0]   bus_wdata,
  output logic [31:0]   acc_out
);
  logic [31:0] src;
  logic        hi_lane;
  logic [15:0] chunk;
  logic [7:0]  lane_byte [LANES];
  logic [LANES-1:0] lane_sel;

  assign src     = wdata >> {step.off, 3'b000};
  assign hi_lane = !narrow && (step.nbytes == 2'd1) && cur_odd;

  always_comb begin
    if (narrow)                  lane_sel = 2'b01;
    else if (step.nbytes == 2'd2) lane_sel = 2'b11;
    else if (cur_odd)            lane_sel = 2'b10;
    else                         lane_sel = 2'b01;
  end
  assign be = lane_sel;

  // per-lane write byte: a full halfword uses each lane's own byte,
  // a single byte lands on whichever lane is strobed
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      if (!lane_sel[g])              lane_byte[g] = 8'h00;
      else if (step.nbytes == 2'd2)  lane_byte[g] = src[8*g +: 8];
      else                           lane_byte[g] = src[7:0];
    end
    assign bus_wdata[8*g +: 8] = lane_byte[g];
  end

  always_comb begin
    if (step.nbytes == 2'd2) chunk = bus_rdata;
    else if (hi_lane)        chunk = {8'h00, bus_rdata[15:8]};
    else                     chunk = {8'h00, bus_rdata[7:0]};
    acc_out = acc_in | ({16'h0000, chunk} << {step.off, 3'b000});
  end
endmodule

// File: rtl/access_splitter.sv
module access_splitter
  import access_splitter_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [31:0]   req_wdata,
  input  logic          req_periph,
  input  logic          cfg_ext_narrow,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata,
  output logic          bus_valid,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_be,
  output logic          bus_write,
  output logic [15:0]   bus_wdata,
  input  logic          bus_ack,
  input  logic [15:0]   bus_rdata
);
  split_state_e     st_q;
  logic [AW-1:0]    base_q;
  logic [OFF_W-1:0] total_q;
  logic [OFF_W-1:0] off_q;
  logic             narrow_q;
  logic             write_q;
  logic [31:0]      wdata_q;
  logic [31:0]      acc_q;

  step_t            step;
  logic [31:0]      acc_next;
  logic             cur_odd;

  split_step u_step (
    .base_lsb (base_q[0]),
    .off      (off_q),
    .total    (total_q),
    .narrow   (narrow_q),
    .step     (step)
  );

  assign cur_odd = base_q[0] ^ off_q[0];

  lane_steer u_lane (
    .step      (step),
    .cur_odd   (cur_odd),
    .narrow    (narrow_q),
    .wdata     (wdata_q),
    .acc_in    (acc_q),
    .bus_rdata (bus_rdata),
    .be        (bus_be),
    .bus_wdata (bus_wdata),
    .acc_out   (acc_next)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign bus_valid = (st_q == ST_XFER);
  assign bus_addr  = base_q + AW'(off_q);
  assign bus_write = write_q;
  assign rsp_valid = (st_q == ST_DONE);
  assign rsp_rdata = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      base_q   <= '0;
      total_q  <= '0;
      off_q    <= '0;
      narrow_q <= 1'b0;
      write_q  <= 1'b0;
      wdata_q  <= '0;
      acc_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid) begin
          base_q   <= req_addr;
          total_q  <= size_to_bytes(req_size);
          off_q    <= '0;
          narrow_q <= cfg_ext_narrow && !req_periph;
          write_q  <= req_write;
          wdata_q  <= req_wdata;
          acc_q    <= '0;
          st_q     <= ST_XFER;
        end
        ST_XFER: if (bus_ack) begin
          off_q <= off_q + OFF_W'(step.nbytes);
          if (!write_q) acc_q <= acc_next;
          if (step.last) st_q <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R8: a held cycle keeps its address and strobes
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ack |=> bus_valid && $stable(bus_addr) && $stable(bus_be)
                              && $stable(bus_wdata) && $stable(bus_write));
  // R2: at least one lane strobed in every cycle
  a_r2_lane_active: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_be != 2'b00);
  // R3: an odd address never carries a full halfword
  a_r3_odd_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_addr[0] |-> $countones(bus_be) == 1);
  // R6: the narrow path only uses lane 0
  a_r6_narrow_lane: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && narrow_q |-> bus_be == 2'b01);
  // R9: done follows the final acknowledge and lasts one cycle
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ack && step.last |=> rsp_valid);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R10: ready low while busy, back after done
  a_r10_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !req_ready);
  a_r10_ready_back: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);
  // R8: after an acknowledge the next cycle moves to a new address
  a_r8_advance: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ack && !step.last |=> bus_valid && bus_addr != $past(bus_addr));
endmodule

// File: tb/tb_access_splitter.sv
module tb_access_splitter;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic          req_write = 1'b0;
  logic [31:0]   req_wdata = '0;
  logic          req_periph = 1'b0;
  logic          cfg_ext_narrow = 1'b0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          bus_valid;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_be;
  logic          bus_write;
  logic [15:0]   bus_wdata;
  logic          bus_ack = 1'b0;
  logic [15:0]   bus_rdata = '0;

  access_splitter #(.AW(AW)) dut (.*);

  always #2.5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  logic [7:0] mem [256];
  logic       bus_narrow = 1'b0;   // bench's view of the active path width
  int         rec_n = 0;
  logic [AW-1:0] rec_addr [8];
  logic [1:0]    rec_be   [8];
  logic          rec_wr   [8];
  int         delay_cnt = 0;
  logic       waiting = 1'b0;
  logic [AW-1:0] wait_addr = '0;
  logic [1:0]    wait_be = '0;

  int exp_n;
  int exp_off [4];
  int exp_wid [4];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected cycle plan, written from the requirement tables
  task automatic plan(input logic [1:0] a, input logic [1:0] sz, input bit nar);
    int nb;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    if (nar) begin
      exp_n = nb;
      for (int i = 0; i < nb; i++) begin exp_off[i] = i; exp_wid[i] = 1; end
    end else if (nb == 1) begin
      exp_n = 1; exp_off[0] = 0; exp_wid[0] = 1;
    end else if (nb == 2) begin
      if (a[0]) begin exp_n = 2; exp_off[0] = 0; exp_wid[0] = 1; exp_off[1] = 1; exp_wid[1] = 1; end
      else      begin exp_n = 1; exp_off[0] = 0; exp_wid[0] = 2; end
    end else if (a[0]) begin
      exp_n = 3; exp_off[0] = 0; exp_wid[0] = 1; exp_off[1] = 1; exp_wid[1] = 2;
      exp_off[2] = 3; exp_wid[2] = 1;
    end else begin
      exp_n = 2; exp_off[0] = 0; exp_wid[0] = 2; exp_off[1] = 2; exp_wid[1] = 2;
    end
  endtask

  // bus model: acts on falling edges
  initial begin
    forever begin
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 1'b0;
      end else if (bus_valid) begin
        if (waiting && (bus_addr != wait_addr || bus_be != wait_be))
          chk(1'b0, "R8 held cycle changed", {16'h0, bus_addr}, {16'h0, wait_addr});
        if (delay_cnt > 0) begin
          delay_cnt--;
          waiting = 1'b1; wait_addr = bus_addr; wait_be = bus_be;
        end else begin
          waiting = 1'b0;
          if (rec_n < 8) begin
            rec_addr[rec_n] = bus_addr; rec_be[rec_n] = bus_be; rec_wr[rec_n] = bus_write;
          end
          rec_n++;
          if (bus_narrow) begin
            bus_rdata = {8'h00, mem[bus_addr[7:0]]};
            if (bus_write) mem[bus_addr[7:0]] = bus_wdata[7:0];
          end else begin
            bus_rdata = {mem[{bus_addr[7:1], 1'b1}], mem[{bus_addr[7:1], 1'b0}]};
            if (bus_write && bus_be[0]) mem[{bus_addr[7:1], 1'b0}] = bus_wdata[7:0];
            if (bus_write && bus_be[1]) mem[{bus_addr[7:1], 1'b1}] = bus_wdata[15:8];
          end
          bus_ack = 1'b1;
          delay_cnt = int'($urandom % 3);
        end
      end
    end
  end

  task automatic txn(input logic [AW-1:0] a, input logic [1:0] sz, input bit wr,
                     input logic [31:0] wd, input bit per, input bit nar_cfg, input string tag);
    logic [7:0]  emem [256];
    logic [31:0] exp_rd;
    int nb, t;
    bit nar;
    nar = nar_cfg && !per;
    nb  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    for (int i = 0; i < 256; i++) emem[i] = mem[i];
    exp_rd = '0;
    for (int i = 0; i < nb; i++) begin
      exp_rd[8*i +: 8] = mem[8'(a + AW'(i))];
      if (wr) emem[8'(a + AW'(i))] = wd[8*i +: 8];
    end
    plan(a[1:0], sz, nar);
    rec_n = 0;
    bus_narrow = nar;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready idle", {31'h0, req_ready}, 32'h1);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
    req_wdata = wd; req_periph = per; cfg_ext_narrow = nar_cfg;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!rsp_valid && t < 60) begin
      if (req_ready) chk(1'b0, "R10 ready while busy", 32'h1, 32'h0);
      @(negedge clk);
      t++;
    end
    chk(rsp_valid == 1'b1, {"R9 done seen ", tag}, {31'h0, rsp_valid}, 32'h1);
    if (!wr) chk(rsp_rdata == exp_rd, {"R9 read data ", tag}, rsp_rdata, exp_rd);
    chk(rec_n == exp_n, {"R8 cycle count ", tag}, 32'(rec_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < rec_n; i++) begin
      logic [AW-1:0] ea;
      logic [1:0]    eb;
      ea = a + AW'(exp_off[i]);
      eb = nar ? 2'b01 : (exp_wid[i] == 2) ? 2'b11 : (ea[0] ? 2'b10 : 2'b01);
      chk(rec_addr[i] == ea, {"R2 cycle address ", tag}, {16'h0, rec_addr[i]}, {16'h0, ea});
      chk(rec_be[i] == eb, {"R2 cycle strobes ", tag}, {30'h0, rec_be[i]}, {30'h0, eb});
      chk(rec_wr[i] == wr, {"R1 direction ", tag}, {31'h0, rec_wr[i]}, {31'h0, wr});
    end
    if (wr) for (int i = 0; i < 256; i++)
      if (mem[i] !== emem[i]) chk(1'b0, {"R2 written byte ", tag}, {24'h0, mem[i]}, {24'h0, emem[i]});
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 single pulse", {31'h0, rsp_valid}, 32'h0);
    chk(req_ready == 1'b1, "R10 ready back", {31'h0, req_ready}, 32'h1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready == 1'b1, "R11 ready in reset", {31'h0, req_ready}, 32'h1);
    chk(bus_valid == 1'b0, "R11 bus idle in reset", {31'h0, bus_valid}, 32'h0);
    chk(rsp_valid == 1'b0, "R11 no done in reset", {31'h0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_valid == 1'b0, "R11 bus idle after reset", {31'h0, bus_valid}, 32'h0);

    // directed corners
    txn(16'h0011, 2'd0, 1'b0, 32'h0, 1'b0, 1'b0, "R1 odd byte read");
    txn(16'h0021, 2'd1, 1'b0, 32'h0, 1'b0, 1'b0, "R3 odd half read");
    txn(16'h0031, 2'd1, 1'b1, 32'h0000BEEF, 1'b0, 1'b0, "R3 odd half write");
    txn(16'h0041, 2'd2, 1'b0, 32'h0, 1'b0, 1'b0, "R4 odd word read");
    txn(16'h0053, 2'd2, 1'b1, 32'hA1B2C3D4, 1'b0, 1'b0, "R4 odd word write");
    txn(16'h0062, 2'd2, 1'b0, 32'h0, 1'b0, 1'b0, "R5 word at 10");
    txn(16'h0070, 2'd2, 1'b1, 32'h11223344, 1'b0, 1'b0, "R5 aligned word");
    txn(16'h0084, 2'd1, 1'b0, 32'h0, 1'b0, 1'b0, "R5 aligned half");
    txn(16'h0091, 2'd2, 1'b0, 32'h0, 1'b0, 1'b1, "R6 narrow word");
    txn(16'h00A0, 2'd1, 1'b1, 32'h00005A5A, 1'b0, 1'b1, "R6 narrow half write");
    txn(16'h00B1, 2'd2, 1'b0, 32'h0, 1'b1, 1'b1, "R7 periph odd word");
    txn(16'h00C2, 2'd1, 1'b1, 32'h0000C0DE, 1'b1, 1'b1, "R7 periph half write");
    txn(16'h00D5, 2'd3, 1'b0, 32'h0, 1'b0, 1'b0, "R1 size code 3");

    // constrained random
    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] ra;
      ra = AW'($urandom % 252);
      txn(ra, 2'($urandom % 3), 1'($urandom), $urandom, 1'($urandom), 1'($urandom), "random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule